// File: doc/BRIEF.md
# Converter Output Demultiplexer with Realignable Half-Rate Divider

This block sits between a sampling converter core and the output pins. It takes one 6-bit sample word on every rising edge of the sample clock and presents it in one of two formats. In split mode, the sample clock is divided by two. Alternate samples are steered onto two output ports that change together once every two sample periods. A half-rate clock is driven out alongside the ports, with its rising edge placed in the middle of the window in which the port data are steady. In straight mode, every sample is copied to port A at the full rate, port B stays at zero, and the clock output is the inverted sample clock.

A synchronous realign input does two things. It forces the divider into a known phase, so that several instances fed from the same realign pulse produce identical port pairs. It is also the only moment at which the mode input is taken in. The converter core cannot be stalled, so the sample path has no valid or ready handshake. A word is accepted on every edge and there is no back-pressure. The realign and mode pins are plain control inputs.

Top module: `adc_out_demux`

## Requirements
- R1: In straight mode, port_a shows the sample presented at a rising clk edge from that edge until the next edge (one register stage). The sample width is the parameter SAMPLE_W, 6 by default.
- R2: In straight mode, port_b reads all zeros.
- R3: In straight mode, clk_out is the inverse of clk: low while clk is high and high while clk is low.
- R4: In split mode, counting the samples accepted after realign is released from 0, even-numbered samples appear on port_a and odd-numbered samples appear on port_b. Both ports change together on the edge that accepts the odd sample, and they hold for the next edge.
- R5: In split mode, clk_out is the internal divider phase. It toggles on every edge outside realign and falls on the edge that updates the ports. It rises one sample period later, in the middle of the two-period valid window.
- R6: While realign is high at a rising edge, the divider is forced to the phase in which clk_out is low and the next sample accepted goes to port_a. A realign pulse that lands where an odd sample would have been paired leaves both ports unchanged.
- R7: mode_sel (1 = split, 0 = straight) is taken in only on edges where realign is high. A change of mode_sel at any other time has no effect, and the outputs keep following the previous mode.
- R8: In straight mode, realign does not disturb the outputs. port_a still takes the sample of a realign edge, and port_b stays zero.
- R9: Two instances given the same samples and mode produce identical port_a, port_b and clk_out on every cycle after a shared realign pulse, whatever their phases were before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; every rising edge accepts one sample |
| realign | input | 1 | Synchronous, active high; resets divider phase and loads the mode |
| mode_sel | input | 1 | 1 = split (two half-rate ports), 0 = straight |
| sample | input | SAMPLE_W | Sample word from the converter core |
| port_a | output | SAMPLE_W | Straight output, or even samples in split mode |
| port_b | output | SAMPLE_W | Odd samples in split mode, zero in straight mode |
| clk_out | output | 1 | Half-rate clock in split mode, inverted clk in straight mode |

## Verification
Two events can fall on the same edge: a realign pulse, and the edge where the odd sample of a pair would update both ports. The bench waits until the divider phase is high and then raises realign on exactly that edge. It checks that the ports keep their old pair, that clk_out comes out low, and that the next two samples land on port_a and then port_b. A mode_sel change can likewise coincide with ordinary pairing edges. The bench flips mode_sel with realign low and requires the split format and divided clock to persist until a realign edge loads the new mode.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;
  typedef enum logic {
    FMT_STRAIGHT = 1'b0,
    FMT_SPLIT    = 1'b1
  } fmt_e;

  localparam int unsigned SAMPLE_W_DEF = 6;
endpackage

// File: rtl/demux_phase_ctl.sv
module demux_phase_ctl
  import adc_demux_pkg::*;
(
  input  logic clk,
  input  logic realign,
  input  logic mode_sel,
  output fmt_e fmt_q,
  output logic phase_q,
  output logic armed_q
);
  // phase_q = 0: next accepted sample is the even one (goes to port A)
  always_ff @(posedge clk) begin
    if (realign) begin
      fmt_q   <= fmt_e'(mode_sel);
      phase_q <= 1'b0;
      armed_q <= 1'b1;
    end else if (fmt_q == FMT_SPLIT) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  AST_ALIGN_PHASE: assert property (@(posedge clk) disable iff (!armed_q)
    realign |=> !phase_q); // R6
  AST_SPLIT_TOGGLE: assert property (@(posedge clk) disable iff (!armed_q)
    (!realign && fmt_q == FMT_SPLIT) |=> (phase_q != $past(phase_q))); // R5
  AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!armed_q)
    !realign |=> $stable(fmt_q)); // R7
endmodule

// File: rtl/demux_steer.sv
module demux_steer
  import adc_demux_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                realign,
  input  logic                armed,
  input  fmt_e                fmt,
  input  logic                phase,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] port_a,
  output logic [SAMPLE_W-1:0] port_b
);
  logic [SAMPLE_W-1:0] even_hold;

  always_ff @(posedge clk) begin
    if (fmt == FMT_STRAIGHT) begin
      port_a <= sample;
      port_b <= '0;
    end else if (!realign) begin
      if (!phase) begin
        even_hold <= sample;
      end else begin
        port_a <= even_hold;
        port_b <= sample;
      end
    end
  end

  AST_STRAIGHT_COPY: assert property (@(posedge clk) disable iff (!armed)
    (fmt == FMT_STRAIGHT) |=> (port_a == $past(sample))); // R1
  AST_STRAIGHT_B_ZERO: assert property (@(posedge clk) disable iff (!armed)
    (fmt == FMT_STRAIGHT) |=> (port_b == '0)); // R2
  AST_SPLIT_PAIR: assert property (@(posedge clk) disable iff (!armed)
    (fmt == FMT_SPLIT && phase && !realign) |=> (port_b == $past(sample))); // R4
  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (fmt == FMT_SPLIT && (!phase || realign)) |=> ($stable(port_a) && $stable(port_b))); // R6
endmodule

// File: rtl/adc_out_demux.sv
module adc_out_demux
  import adc_demux_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                realign,
  input  logic                mode_sel,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] port_a,
  output logic [SAMPLE_W-1:0] port_b,
  output logic                clk_out
);
  fmt_e fmt_q;
  logic phase_q;
  logic armed_q;

  demux_phase_ctl u_phase (
    .clk      (clk),
    .realign  (realign),
    .mode_sel (mode_sel),
    .fmt_q    (fmt_q),
    .phase_q  (phase_q),
    .armed_q  (armed_q)
  );

  demux_steer #(.SAMPLE_W(SAMPLE_W)) u_steer (
    .clk     (clk),
    .realign (realign),
    .armed   (armed_q),
    .fmt     (fmt_q),
    .phase   (phase_q),
    .sample  (sample),
    .port_a  (port_a),
    .port_b  (port_b)
  );

  // divided phase in split mode, inverted sample clock in straight mode
  assign clk_out = (fmt_q == FMT_SPLIT) ? phase_q : ~clk;

  AST_CLKOUT_LOW_AFTER_ALIGN: assert property (@(posedge clk) disable iff (!armed_q)
    (realign && mode_sel) |=> !clk_out); // R6
endmodule

// File: tb/adc_out_demux_test.sv
module adc_out_demux_test;
  localparam int PER = 10;
  localparam int W   = 6;

  logic clk = 1'b0;
  always #(PER/2) clk = ~clk;

  logic         realign = 1'b1;
  logic         realign_x = 1'b0;
  logic         mode_sel = 1'b1;
  logic [W-1:0] sample = '0;
  logic [W-1:0] a, b, a2, b2;
  logic         ck, ck2;

  adc_out_demux #(.SAMPLE_W(W)) uut (
    .clk(clk), .realign(realign), .mode_sel(mode_sel), .sample(sample),
    .port_a(a), .port_b(b), .clk_out(ck));

  adc_out_demux #(.SAMPLE_W(W)) uut_b (
    .clk(clk), .realign(realign | realign_x), .mode_sel(mode_sel), .sample(sample),
    .port_a(a2), .port_b(b2), .clk_out(ck2));

  // expected-value model built from the requirements
  logic         m_armed = 1'b0, m_mode = 1'b0, m_phase = 1'b0;
  logic [W-1:0] m_hold = '0, m_a = '0, m_b = '0;

  always @(posedge clk) begin
    if (realign) begin
      m_armed <= 1'b1;
      m_mode  <= mode_sel;
      m_phase <= 1'b0;
      if (!m_mode) begin m_a <= sample; m_b <= '0; end
    end else if (m_mode) begin
      if (!m_phase) m_hold <= sample;
      else begin m_a <= m_hold; m_b <= sample; end
      m_phase <= ~m_phase;
    end else begin
      m_a <= sample;
      m_b <= '0;
    end
  end

  int errs = 0;
  int checks = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at the next negedge
  task automatic step(input logic ra, input logic ms, input logic [W-1:0] s, input string force_tag);
    string ta, tb, tc;
    realign  = ra;
    mode_sel = ms;
    sample   = s;
    @(posedge clk);
    #(PER/4);
    if (m_armed && !m_mode) chk("R3 clk_out while clk high", ck, 0);
    @(negedge clk);
    if (m_armed) begin
      ta = m_mode ? "R4 port_a" : "R1 port_a";
      tb = m_mode ? "R4 port_b" : "R2 port_b";
      tc = m_mode ? "R5 clk_out" : "R3 clk_out while clk low";
      if (mode_sel != m_mode) begin ta = "R7 port_a"; tb = "R7 port_b"; tc = "R7 clk_out"; end
      if (force_tag != "") begin ta = force_tag; tb = force_tag; tc = force_tag; end
      chk(ta, a, m_a);
      chk(tb, b, m_b);
      chk(tc, ck, m_mode ? m_phase : 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    step(1'b1, 1'b1, 6'd0, "R6");
    step(1'b1, 1'b1, 6'd0, "R6");
    chk("R6 clk_out low after realign", ck, 0);
    // counting sequence in split mode
    step(1'b0, 1'b1, 6'd0, "");
    step(1'b0, 1'b1, 6'd1, "");
    chk("R4 count port_a", a, 0);
    chk("R4 count port_b", b, 1);
    chk("R5 clk_out falls at update", ck, 0);
    step(1'b0, 1'b1, 6'd2, "");
    chk("R5 clk_out rises mid-window", ck, 1);
    chk("R5 port_a steady", a, 0);
    step(1'b0, 1'b1, 6'd3, "");
    chk("R4 count port_a second pair", a, 2);
    chk("R4 count port_b second pair", b, 3);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, W'($urandom), "");
    // realign on the edge that would pair an odd sample
    if (!m_phase) step(1'b0, 1'b1, W'($urandom), "");
    begin
      logic [W-1:0] pa, pb;
      pa = a; pb = b;
      step(1'b1, 1'b1, 6'd50, "R6");
      chk("R6 port_a held on colliding realign", a, pa);
      chk("R6 port_b held on colliding realign", b, pb);
      chk("R6 clk_out low", ck, 0);
    end
    step(1'b0, 1'b1, 6'd10, "");
    step(1'b0, 1'b1, 6'd11, "");
    chk("R6 first sample to port_a", a, 10);
    chk("R6 second sample to port_b", b, 11);
    // mode change without realign is ignored
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, W'($urandom), "");
    chk("R7 port_b still split data", b, m_b);
    // enter straight mode
    step(1'b1, 1'b0, 6'd5, "");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, W'($urandom), "");
    step(1'b1, 1'b0, 6'd33, "R8");
    chk("R8 port_a passes realign sample", a, 33);
    chk("R8 port_b zero", b, 0);
    step(1'b0, 1'b1, 6'd7, "R7");
    chk("R7 straight persists", a, 7);
    // two instances, put out of step, then realigned together
    step(1'b1, 1'b1, 6'd0, "");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, W'($urandom), "");
    realign_x = 1'b1;
    step(1'b0, 1'b1, W'($urandom), "");
    realign_x = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, W'($urandom), "");
    step(1'b1, 1'b1, W'($urandom), "");
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, W'($urandom), "");
      chk("R9 port_a match", a2, a);
      chk("R9 port_b match", b2, b);
      chk("R9 clk_out match", ck2, ck);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(PER*200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule